// File: doc/BRIEF.md
# Read Request Completion Credit Throttle

This block sits in front of a transaction-layer request port and lets a memory read out only when the receive side can absorb everything that read may bring back. The link partner is told that completion credits are unlimited, so nothing outside the endpoint will hold returning data back. The block therefore keeps its own account of completion data bytes and completion header slots. It holds a read until both are reserved and a tag is free. The header reservation assumes the worst case, in which the completer splits the data at every 64-byte boundary.

Each issued read takes the lowest free tag. A per-tag table records how many bytes and header slots remain reserved for that tag. Returning completions release data by their byte count and one header slot each. The completion flagged as last hands back whatever is left and returns the tag to the pool. Configuration inputs set the usable tag count (32 or 64), the reserved data space, the header slot total and the largest permitted read size.

Top module: `rdreq_credit_gate`

## Requirements
- R1: After synchronous reset all tags are free and nothing is reserved. out_valid, out_reject and cpl_err are low, and a legal request of any size within the configured space is ready at once.
- R2: An accepted request appears on the out_* port one cycle after its acceptance, with out_valid high for exactly one cycle and its address and length unchanged. A request that cannot be accepted sees req_ready low and is not issued.
- R3: An issued read carries the lowest-numbered free tag.
- R4: With cfg_tag64 = 0 only tags 0 to 31 are used, so a 33rd outstanding read is held. With cfg_tag64 = 1 tags 0 to 63 are used, so a 65th is held.
- R5: Each read reserves ceil(length/64) header slots. It is held when the slots in use plus this amount would exceed cfg_hdr_slots.
- R6: A read is held when the reserved data bytes plus its length would exceed cfg_data_space.
- R7: A request with length 0 or length above cfg_max_rd is consumed with req_ready high. It raises out_reject for one cycle on the next cycle, is never issued and reserves nothing.
- R8: A completion without the last flag for a busy tag releases min(byte count, bytes still reserved for the tag) data bytes and one header slot, if any slot is left. The tag stays busy.
- R9: A completion with the last flag for a busy tag releases all data bytes and header slots still reserved for that tag and frees the tag.
- R10: A completion for a tag that is not in use raises cpl_err for one cycle on the next cycle and releases nothing.
- R11: The reserved byte and slot totals never exceed their configured totals and never wrap below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_tag64 | input | 1 | 1: 64 usable tags, 0: 32 usable tags |
| cfg_data_space | input | 16 | Completion data bytes that may be reserved |
| cfg_hdr_slots | input | 10 | Completion header slots that may be reserved |
| cfg_max_rd | input | 13 | Largest legal read length in bytes |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request taken this cycle (issued or rejected) |
| req_addr | input | ADDR_W (64) | Read address |
| req_len | input | 13 | Read length in bytes |
| out_valid | output | 1 | Issued read present, one cycle |
| out_addr | output | ADDR_W (64) | Issued read address |
| out_len | output | 13 | Issued read length |
| out_tag | output | 6 | Tag assigned to the issued read |
| out_reject | output | 1 | Illegal-length request dropped, one cycle |
| cpl_valid | input | 1 | Completion arrived |
| cpl_tag | input | 6 | Tag of the completion |
| cpl_bytes | input | 13 | Data bytes carried by the completion |
| cpl_last | input | 1 | Final completion for the tag |
| cpl_err | output | 1 | Completion for an idle tag, one cycle |

## Verification
The hardest case to reach is a read held back by a single resource while the other two are plentiful. Here the header slots run out before the data space or the tags do. A partial completion must then release exactly one slot, and no more, to let the read through. The stimulus gets there by setting a tiny slot total with large data space. A 129-byte read uses three slots, so a 128-byte read is held while a 64-byte read still fits. One non-last completion then admits a second 64-byte read but not a 128-byte one. Tag exhaustion is reached in the same way by filling all 32 or 64 tags with small reads under generous byte and slot totals.

// File: rtl/rdcg_pkg.sv
package rdcg_pkg;
    localparam int NTAG     = 64;
    localparam int TAG_W    = $clog2(NTAG);
    localparam int LEN_W    = 13;
    localparam int SPACE_W  = 16;
    localparam int SLOT_W   = 10;
    localparam int CB_LOG2  = 6;
    localparam int RSLOT_W  = LEN_W - CB_LOG2 + 1;

    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [LEN_W-1:0]   len_t;
    typedef logic [RSLOT_W-1:0] rslot_t;

    typedef struct packed {
        len_t   bytes;
        rslot_t slots;
    } resv_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
        len_t bytes;
        logic last;
    } cpl_t;

    function automatic rslot_t slots_for(len_t len);
        logic [LEN_W:0] s;
        s = {1'b0, len} + (LEN_W+1)'((1 << CB_LOG2) - 1);
        return s[LEN_W:CB_LOG2];
    endfunction
endpackage

// File: rtl/rdcg_tag_alloc.sv
module rdcg_tag_alloc
    import rdcg_pkg::*;
(
    input  logic [NTAG-1:0] busy,
    input  logic            cfg_tag64,
    output logic            avail,
    output tag_t            tag
);
    localparam int HALF = NTAG / 2;

    int limit;
    assign limit = cfg_tag64 ? NTAG : HALF;

    always_comb begin
        avail = 1'b0;
        tag   = '0;
        for (int i = NTAG - 1; i >= 0; i--) begin
            if (!busy[i] && i < limit) begin
                avail = 1'b1;
                tag   = tag_t'(i);
            end
        end
    end
endmodule

// File: rtl/rdcg_tag_table.sv
module rdcg_tag_table
    import rdcg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            alloc_en,
    input  tag_t            alloc_tag,
    input  resv_t           alloc_resv,
    input  cpl_t            cpl,
    output logic [NTAG-1:0] busy,
    output resv_t           release_amt,
    output logic            cpl_miss
);
    len_t   rem_bytes [NTAG];
    rslot_t rem_slots [NTAG];

    logic   hit;
    len_t   rb;
    rslot_t rs;
    resv_t  rel;

    assign hit      = cpl.valid &&  busy[cpl.tag];
    assign cpl_miss = cpl.valid && !busy[cpl.tag];
    assign rb       = rem_bytes[cpl.tag];
    assign rs       = rem_slots[cpl.tag];

    always_comb begin
        rel = '0;
        if (hit) begin
            if (cpl.last) begin
                rel.bytes = rb;
                rel.slots = rs;
            end else begin
                rel.bytes = (cpl.bytes < rb) ? cpl.bytes : rb;
                rel.slots = (rs != '0) ? rslot_t'(1) : '0;
            end
        end
    end
    assign release_amt = rel;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= '0;
            for (int i = 0; i < NTAG; i++) begin
                rem_bytes[i] <= '0;
                rem_slots[i] <= '0;
            end
        end else begin
            if (hit) begin
                rem_bytes[cpl.tag] <= rb - rel.bytes;
                rem_slots[cpl.tag] <= rs - rel.slots;
                if (cpl.last) busy[cpl.tag] <= 1'b0;
            end
            if (alloc_en) begin
                busy[alloc_tag]      <= 1'b1;
                rem_bytes[alloc_tag] <= alloc_resv.bytes;
                rem_slots[alloc_tag] <= alloc_resv.slots;
            end
        end
    end

    AST_LAST_FREES_TAG: assert property (@(posedge clk) disable iff (rst)
        (hit && cpl.last && !(alloc_en && alloc_tag == cpl.tag)) |=> !busy[$past(cpl.tag)]); // R9
    AST_NONLAST_KEEPS_TAG: assert property (@(posedge clk) disable iff (rst)
        (hit && !cpl.last) |=> busy[$past(cpl.tag)]); // R8
endmodule

// File: rtl/rdcg_credit_ctr.sv
module rdcg_credit_ctr
    import rdcg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SPACE_W-1:0] cfg_data_space,
    input  logic [SLOT_W-1:0]  cfg_hdr_slots,
    input  resv_t              want,
    input  logic               take,
    input  resv_t              give_back,
    output logic               data_fit,
    output logic               slot_fit
);
    logic [SPACE_W-1:0] data_used;
    logic [SLOT_W-1:0]  slot_used;

    logic [SPACE_W:0] dsum;
    logic [SLOT_W:0]  ssum;

    assign dsum     = {1'b0, data_used} + (SPACE_W+1)'(want.bytes);
    assign ssum     = {1'b0, slot_used} + (SLOT_W+1)'(want.slots);
    assign data_fit = dsum <= {1'b0, cfg_data_space};
    assign slot_fit = ssum <= {1'b0, cfg_hdr_slots};

    always_ff @(posedge clk) begin
        if (rst) begin
            data_used <= '0;
            slot_used <= '0;
        end else begin
            data_used <= data_used
                       + (take ? SPACE_W'(want.bytes) : '0)
                       - SPACE_W'(give_back.bytes);
            slot_used <= slot_used
                       + (take ? SLOT_W'(want.slots) : '0)
                       - SLOT_W'(give_back.slots);
        end
    end

    AST_DATA_LIMIT: assert property (@(posedge clk) disable iff (rst)
        data_used <= cfg_data_space); // R11
    AST_HDR_LIMIT: assert property (@(posedge clk) disable iff (rst)
        slot_used <= cfg_hdr_slots); // R11
    AST_DATA_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        SPACE_W'(give_back.bytes) <= data_used); // R11
    AST_HDR_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        SLOT_W'(give_back.slots) <= slot_used); // R11
endmodule

// File: rtl/rdreq_credit_gate.sv
module rdreq_credit_gate
    import rdcg_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_tag64,
    input  logic [SPACE_W-1:0]   cfg_data_space,
    input  logic [SLOT_W-1:0]    cfg_hdr_slots,
    input  logic [LEN_W-1:0]     cfg_max_rd,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    output logic                 out_valid,
    output logic [ADDR_W-1:0]    out_addr,
    output logic [LEN_W-1:0]     out_len,
    output logic [TAG_W-1:0]     out_tag,
    output logic                 out_reject,
    input  logic                 cpl_valid,
    input  logic [TAG_W-1:0]     cpl_tag,
    input  logic [LEN_W-1:0]     cpl_bytes,
    input  logic                 cpl_last,
    output logic                 cpl_err
);
    localparam int HALF = NTAG / 2;

    logic [NTAG-1:0] busy;
    logic            tag_ok;
    tag_t            free_tag;
    logic            data_fit;
    logic            slot_fit;
    logic            bad_len;
    logic            issue;
    logic            drop;
    logic            cpl_miss;
    resv_t           want;
    resv_t           give_back;
    cpl_t            cpl;

    assign want.bytes = req_len;
    assign want.slots = slots_for(req_len);
    assign cpl        = '{valid: cpl_valid, tag: cpl_tag, bytes: cpl_bytes, last: cpl_last};

    assign bad_len   = (req_len == '0) || (req_len > cfg_max_rd);
    assign req_ready = bad_len || (tag_ok && data_fit && slot_fit);
    assign issue     = req_valid && !bad_len && tag_ok && data_fit && slot_fit;
    assign drop      = req_valid && bad_len;

    rdcg_tag_alloc u_alloc (
        .busy      (busy),
        .cfg_tag64 (cfg_tag64),
        .avail     (tag_ok),
        .tag       (free_tag)
    );

    rdcg_tag_table u_table (
        .clk         (clk),
        .rst         (rst),
        .alloc_en    (issue),
        .alloc_tag   (free_tag),
        .alloc_resv  (want),
        .cpl         (cpl),
        .busy        (busy),
        .release_amt (give_back),
        .cpl_miss    (cpl_miss)
    );

    rdcg_credit_ctr u_credit (
        .clk            (clk),
        .rst            (rst),
        .cfg_data_space (cfg_data_space),
        .cfg_hdr_slots  (cfg_hdr_slots),
        .want           (want),
        .take           (issue),
        .give_back      (give_back),
        .data_fit       (data_fit),
        .slot_fit       (slot_fit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_addr   <= '0;
            out_len    <= '0;
            out_tag    <= '0;
            out_reject <= 1'b0;
            cpl_err    <= 1'b0;
        end else begin
            out_valid  <= issue;
            out_reject <= drop;
            cpl_err    <= cpl_miss;
            if (issue) begin
                out_addr <= req_addr;
                out_len  <= req_len;
                out_tag  <= free_tag;
            end
        end
    end

    AST_TAG_CAP: assert property (@(posedge clk) disable iff (rst)
        $countones(busy) <= (cfg_tag64 ? NTAG : HALF)); // R4
    AST_IDLE_CPL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !busy[cpl_tag]) |=> cpl_err); // R10
    AST_REJECT_NOT_ISSUED: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_reject)); // R7
    AST_ISSUE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !bad_len) |=> out_valid); // R2
endmodule

// File: tb/sim_rdreq_credit_gate.sv
`timescale 1ns/1ps
module sim_rdreq_credit_gate;
    localparam int ADDR_W = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_tag64;
    logic [15:0] cfg_data_space;
    logic [9:0]  cfg_hdr_slots;
    logic [12:0] cfg_max_rd;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_addr;
    logic [12:0] req_len;
    logic        out_valid;
    logic [63:0] out_addr;
    logic [12:0] out_len;
    logic [5:0]  out_tag;
    logic        out_reject;
    logic        cpl_valid;
    logic [5:0]  cpl_tag;
    logic [12:0] cpl_bytes;
    logic        cpl_last;
    logic        cpl_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rdreq_credit_gate #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .cfg_tag64(cfg_tag64),
        .cfg_data_space(cfg_data_space), .cfg_hdr_slots(cfg_hdr_slots),
        .cfg_max_rd(cfg_max_rd), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .out_valid(out_valid),
        .out_addr(out_addr), .out_len(out_len), .out_tag(out_tag),
        .out_reject(out_reject), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .cpl_bytes(cpl_bytes), .cpl_last(cpl_last), .cpl_err(cpl_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit t64, input int space, input int slots, input int maxrd);
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; cpl_valid = 1'b0;
        req_addr = '0; req_len = '0; cpl_tag = '0; cpl_bytes = '0; cpl_last = 1'b0;
        cfg_tag64 = t64; cfg_data_space = 16'(space);
        cfg_hdr_slots = 10'(slots); cfg_max_rd = 13'(maxrd);
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    // mode: 0 held, 1 issued, 2 rejected
    task automatic send_req(input int len, input int mode, input int tag, input string req);
        logic [63:0] a;
        @(negedge clk);
        a = 64'h1000_0000 + 64'(len) * 64'h40 + 64'(tag);
        req_valid = 1'b1; req_len = 13'(len); req_addr = a;
        #1;
        check(req_ready == (mode != 0), req, req_ready, mode != 0);
        @(negedge clk);
        req_valid = 1'b0;
        check(out_valid == (mode == 1), req, out_valid, mode == 1);
        check(out_reject == (mode == 2), req, out_reject, mode == 2);
        if (mode == 1) begin
            check(out_tag == 6'(tag), req, out_tag, tag);
            check(out_len == 13'(len) && out_addr == a, req, out_len, len);
        end
    endtask

    task automatic send_cpl(input int tag, input int bytes, input bit last, input bit err, input string req);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_tag = 6'(tag); cpl_bytes = 13'(bytes); cpl_last = last;
        @(negedge clk);
        cpl_valid = 1'b0;
        check(cpl_err == err, req, cpl_err, err);
    endtask

    task automatic t_reset();
        do_reset(1'b1, 4096, 64, 4096);
        check(out_valid == 1'b0 && out_reject == 1'b0 && cpl_err == 1'b0, "R1", out_valid, 0);
        send_req(4096, 1, 0, "R1");
    endtask

    task automatic t_tags32();
        do_reset(1'b0, 65535, 1023, 4096);
        for (int i = 0; i < 32; i++) send_req(64, 1, i, "R3");
        send_req(64, 0, 0, "R4");
        send_cpl(2, 64, 1'b0, 1'b0, "R8");
        send_req(64, 0, 0, "R8");
        send_cpl(5, 0, 1'b1, 1'b0, "R9");
        send_req(64, 1, 5, "R9");
        send_cpl(20, 64, 1'b1, 1'b0, "R9");
        send_cpl(7, 64, 1'b1, 1'b0, "R9");
        send_req(32, 1, 7, "R3");
        send_req(32, 1, 20, "R3");
    endtask

    task automatic t_tags64();
        do_reset(1'b1, 65535, 1023, 4096);
        for (int i = 0; i < 64; i++) send_req(16, 1, i, "R4");
        send_req(16, 0, 0, "R4");
    endtask

    task automatic t_data();
        do_reset(1'b1, 256, 1023, 4096);
        send_req(256, 1, 0, "R6");
        send_req(64, 0, 0, "R6");
        send_cpl(9, 64, 1'b1, 1'b1, "R10");
        send_req(1, 0, 0, "R10");
        send_cpl(0, 64, 1'b0, 1'b0, "R8");
        send_req(65, 0, 0, "R8");
        send_req(64, 1, 1, "R8");
        send_req(1, 0, 0, "R6");
        send_cpl(0, 0, 1'b1, 1'b0, "R9");
        send_req(193, 0, 0, "R9");
        send_req(192, 1, 0, "R9");
    endtask

    task automatic t_hdr();
        do_reset(1'b1, 65535, 4, 4096);
        send_req(129, 1, 0, "R5");
        send_req(128, 0, 0, "R5");
        send_req(64, 1, 1, "R5");
        send_cpl(0, 10, 1'b0, 1'b0, "R8");
        send_req(128, 0, 0, "R8");
        send_req(64, 1, 2, "R8");
        send_cpl(0, 10, 1'b1, 1'b0, "R9");
        send_req(128, 1, 0, "R9");
    endtask

    task automatic t_oversize();
        do_reset(1'b1, 512, 1023, 512);
        send_req(513, 2, 0, "R7");
        send_req(0, 2, 0, "R7");
        send_req(512, 1, 0, "R7");
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; cpl_valid = 1'b0;
        cfg_tag64 = 1'b1; cfg_data_space = '0; cfg_hdr_slots = '0; cfg_max_rd = '0;
        req_addr = '0; req_len = '0; cpl_tag = '0; cpl_bytes = '0; cpl_last = 1'b0;
        t_reset();
        t_tags32();
        t_tags64();
        t_data();
        t_hdr();
        t_oversize();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule